// File: doc/BRIEF.md
# Two-tier prioritized interrupt controller

This block gathers one-cycle event strobes from a bank of peripheral sources (32 by default) and turns them into a single interrupt request toward a processor core. Each strobe passes through a two-flop synchronizer and then sets a sticky pending flag for its source. A flag stays set until the core acknowledges that source by index. Repeated strobes while a flag is set are simply absorbed, so events are never counted.

Software configures each source through a simple write port with three values: an urgency level (1..7, where 0 parks the source), a tie-break rank inside the level (0..8, where larger wins), and a per-source block bit. The controller ranks every source that is pending, unblocked and parked at no level zero. Level decides first, then the tie-break rank, then the lower source index. The winner's level is compared against the core's 3-bit mask, and a request is raised when it is strictly above the mask or when the level is 7. A master enable gates the whole request path. On a vector read the controller answers one cycle later with 64 plus the winning index, or with 24 when nothing qualifies.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: A one-cycle strobe on `src_evt[i]`, applied before clock edge k, sets source i pending at edge k+2. Its effect shows on `irq_req` after that edge and never earlier.
- R2: A source whose block bit is 1 is never selected, but its pending flag is kept. Clearing the block bit later lets the held event raise a request.
- R3: While `glb_en` is 0, `irq_req` is 0 and `irq_lvl` is 0.
- R4: Among qualifying sources, the one with the higher level wins, whatever the tie-break ranks are.
- R5: Within one level, the higher tie-break rank wins. A written rank above 8 is stored as 8.
- R6: When level and rank are both equal, the lower source index wins.
- R7: `irq_req` is 1 only when the winner's level is strictly greater than `core_mask`, or when the level is 7 (then the mask has no effect). `irq_lvl` carries the winner's level when `irq_req` is 1, and 0 otherwise.
- R8: Pending flags do not count. Further strobes on a source that is already pending are dropped, and a single acknowledge clears the source.
- R9: `ack_vld` with `ack_idx` = i clears only source i. If an acknowledge and a synchronized strobe reach the same source on the same edge, the source stays pending.
- R10: A `vec_rd` pulse while `irq_req` is 1 yields `vec_vld` = 1 and `vec_num` = 64 + winner index on the following cycle.
- R11: A `vec_rd` pulse while `irq_req` is 0 yields `vec_num` = 24 on the following cycle.
- R12: A source configured with level 0 never requests, even when it is pending and unblocked.
- R13: After reset, every source is cleared, blocked and at level 0, and `irq_req`, `irq_lvl`, `vec_vld` and `vec_num` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_evt | input | N_SRC | One-cycle event strobes, one per source |
| glb_en | input | 1 | Master enable for the request path |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W | Source index being configured |
| cfg_lvl | input | 3 | Level to store (0 parks the source) |
| cfg_sub | input | 4 | Tie-break rank within the level (saturates at 8) |
| cfg_dis | input | 1 | Block bit to store |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_idx | input | IDX_W | Source being acknowledged |
| core_mask | input | 3 | Core interrupt mask level |
| irq_req | output | 1 | Request to the core |
| irq_lvl | output | 3 | Level of the presented request |
| vec_rd | input | 1 | Vector fetch strobe from the core |
| vec_vld | output | 1 | Vector answer valid, one cycle after `vec_rd` |
| vec_num | output | 8 | Returned vector number |

## Verification
The hardest case to produce from the ports is an acknowledge and a new strobe meeting on the same edge. The strobe goes through two synchronizer stages, so the bench raises the event first and holds the acknowledge back two cycles, which makes both land on the third edge. A second hard case is a source whose event arrives while it is blocked. The bench shows that the flag was held by clearing the block bit and watching the request appear with no new event. A table then pairs two sources per row so that level, rank and index ordering, the mask boundary and the level-7 bypass each decide one outcome.

// File: rtl/lvl_irq_pkg.sv
// Package: shared constants and the rank type for the leveled interrupt controller.
// Assumes levels fit in 3 bits and tie-break ranks fit in 4 bits.
package lvl_irq_pkg;
    localparam int LVL_W    = 3;
    localparam int SUB_W    = 4;
    localparam int SUB_MAX  = 8;
    localparam int VEC_BASE = 64;
    localparam int VEC_SPUR = 24;
    localparam logic [LVL_W-1:0] LVL_TOP = 3'd7;

    // Ordering key: comparing as a packed value puts level first, then rank.
    typedef struct packed {
        logic [LVL_W-1:0] lvl;
        logic [SUB_W-1:0] sub;
    } rank_t;
endpackage

// File: rtl/irq_evt_sync.sv
// Two-flop synchronizer for the event strobe bank.
// Assumes each strobe is at least one clock wide in this clock domain.
module irq_evt_sync #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] evt_i,
    output logic [N_SRC-1:0] evt_o
);
    logic [N_SRC-1:0] stage1;

    // Shift the raw strobes through both stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '0;
            evt_o  <= '0;
        end else begin
            stage1 <= evt_i;
            evt_o  <= stage1;
        end
    end
endmodule

// File: rtl/irq_pend_bank.sv
// Sticky pending flags, one per source. A flag is set by a synchronized event
// and cleared only by an acknowledge naming that source; when both happen on
// the same edge, the set wins. Assumes ack_idx is below N_SRC when ack_vld is high.
module irq_pend_bank #(
    parameter int N_SRC = 32,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set_i,
    input  logic             ack_vld,
    input  logic [IDX_W-1:0] ack_idx,
    output logic [N_SRC-1:0] pend_o
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_pend
        logic clr;
        assign clr = ack_vld && (ack_idx == IDX_W'(g));

        // Hold one flag: a set has priority over a clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_o[g] <= 1'b0;
            else
                pend_o[g] <= set_i[g] | (pend_o[g] & ~clr);
        end
    end
endmodule

// File: rtl/irq_cfg_regs.sv
// Per-source configuration: level, tie-break rank (saturated at SUB_MAX) and block bit.
// One source is written per cycle. Reset leaves every source blocked at level 0.
module irq_cfg_regs
    import lvl_irq_pkg::*;
#(
    parameter int N_SRC = 32,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [IDX_W-1:0]   idx,
    input  logic [LVL_W-1:0]   lvl,
    input  logic [SUB_W-1:0]   sub,
    input  logic               dis,
    output rank_t [N_SRC-1:0]  rank_o,
    output logic [N_SRC-1:0]   dis_o
);
    logic [SUB_W-1:0] sub_sat;

    // Clamp the written rank to the legal range.
    always_comb begin
        sub_sat = (sub > SUB_W'(SUB_MAX)) ? SUB_W'(SUB_MAX) : sub;
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_cfg
        // Store the configuration of one source.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rank_o[g] <= '0;
                dis_o[g]  <= 1'b1;
            end else if (wr && idx == IDX_W'(g)) begin
                rank_o[g] <= '{lvl: lvl, sub: sub_sat};
                dis_o[g]  <= dis;
            end
        end
    end
endmodule

// File: rtl/irq_rank_sel.sv
// Picks the eligible source with the largest rank key. On equal keys the
// lower index wins, because only a strictly larger key replaces the current best.
// Purely combinational.
module irq_rank_sel
    import lvl_irq_pkg::*;
#(
    parameter int N_SRC = 32,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]  elig_i,
    input  rank_t [N_SRC-1:0] rank_i,
    output logic              win_vld,
    output logic [IDX_W-1:0]  win_idx,
    output rank_t             win_rank
);
    // Scan the sources from index 0 upward and keep the best candidate.
    always_comb begin
        win_vld  = 1'b0;
        win_idx  = '0;
        win_rank = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig_i[i] && (!win_vld || rank_i[i] > win_rank)) begin
                win_vld  = 1'b1;
                win_idx  = IDX_W'(i);
                win_rank = rank_i[i];
            end
        end
    end
endmodule

// File: rtl/lvl_irq_ctrl.sv
// Top of the two-tier prioritized interrupt controller. It synchronizes the
// event strobes, keeps the sticky pending flags, ranks the eligible sources,
// gates the winner against the core mask, and answers vector fetches one cycle later.
// Assumes N_SRC + 64 fits in 8 bits.
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
#(
    parameter int N_SRC = 32,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_evt,
    input  logic             glb_en,
    input  logic             cfg_wr,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [2:0]       cfg_lvl,
    input  logic [3:0]       cfg_sub,
    input  logic             cfg_dis,
    input  logic             ack_vld,
    input  logic [IDX_W-1:0] ack_idx,
    input  logic [2:0]       core_mask,
    output logic             irq_req,
    output logic [2:0]       irq_lvl,
    input  logic             vec_rd,
    output logic             vec_vld,
    output logic [7:0]       vec_num
);
    logic [N_SRC-1:0]  evt_sync;
    logic [N_SRC-1:0]  pend;
    rank_t [N_SRC-1:0] rank;
    logic [N_SRC-1:0]  dis;
    logic [N_SRC-1:0]  elig;
    logic              win_vld;
    logic [IDX_W-1:0]  win_idx;
    rank_t             win_rank;
    logic              lvl_pass;

    irq_evt_sync #(.N_SRC(N_SRC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .evt_i (src_evt),
        .evt_o (evt_sync)
    );

    irq_pend_bank #(.N_SRC(N_SRC)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (evt_sync),
        .ack_vld (ack_vld),
        .ack_idx (ack_idx),
        .pend_o  (pend)
    );

    irq_cfg_regs #(.N_SRC(N_SRC)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cfg_wr),
        .idx    (cfg_idx),
        .lvl    (cfg_lvl),
        .sub    (cfg_sub),
        .dis    (cfg_dis),
        .rank_o (rank),
        .dis_o  (dis)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        assign elig[g] = pend[g] & ~dis[g] & (rank[g].lvl != '0);
    end

    irq_rank_sel #(.N_SRC(N_SRC)) u_sel (
        .elig_i   (elig),
        .rank_i   (rank),
        .win_vld  (win_vld),
        .win_idx  (win_idx),
        .win_rank (win_rank)
    );

    // Compare the winner's level with the mask; the top level bypasses the mask.
    always_comb begin
        lvl_pass = (win_rank.lvl > core_mask) || (win_rank.lvl == LVL_TOP);
        irq_req  = glb_en && win_vld && lvl_pass;
        irq_lvl  = irq_req ? win_rank.lvl : '0;
    end

    // Register the vector answer for a fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_vld <= 1'b0;
            vec_num <= '0;
        end else begin
            vec_vld <= vec_rd;
            if (vec_rd)
                vec_num <= irq_req ? 8'(VEC_BASE) + 8'(win_idx) : 8'(VEC_SPUR);
        end
    end
endmodule

// File: rtl/lvl_irq_ctrl_chk.sv
// Checker for the port-level rules of lvl_irq_ctrl; it is attached by bind below.
module lvl_irq_ctrl_chk #(
    parameter int N_SRC = 32
) (
    input logic       clk,
    input logic       rst_n,
    input logic       glb_en,
    input logic [2:0] core_mask,
    input logic       irq_req,
    input logic [2:0] irq_lvl,
    input logic       vec_rd,
    input logic       vec_vld,
    input logic [7:0] vec_num
);
    a_r3_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |-> (!irq_req && irq_lvl == 3'd0));

    a_r7_above_mask: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_lvl > core_mask || irq_lvl == 3'd7));

    a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_lvl == 3'd0);

    a_r12_nonzero_level: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_lvl != 3'd0);

    a_r10_vector_range: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && irq_req) |=> (vec_vld && vec_num >= 8'd64 && vec_num < 8'(64 + N_SRC)));

    a_r11_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_rd && !irq_req) |=> (vec_vld && vec_num == 8'd24));
endmodule

bind lvl_irq_ctrl lvl_irq_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en    (glb_en),
    .core_mask (core_mask),
    .irq_req   (irq_req),
    .irq_lvl   (irq_lvl),
    .vec_rd    (vec_rd),
    .vec_vld   (vec_vld),
    .vec_num   (vec_num)
);

// File: tb/lvl_irq_ctrl_bench.sv
// Testbench for lvl_irq_ctrl: a table of paired-source cases walked by one
// loop, then directed checks of reset, timing and corner cases.
module lvl_irq_ctrl_bench;
    localparam int N_SRC   = 32;
    localparam int CLK_PER = 10;
    localparam int NROW    = 8;

    typedef struct packed {
        logic [4:0] ia; logic [2:0] la; logic [3:0] sa;
        logic [4:0] ib; logic [2:0] lb; logic [3:0] sb;
        logic [2:0] msk;
        logic       er;
        logic [2:0] el;
        logic [7:0] ev;
    } row_t;

    localparam row_t TBL [NROW] = '{
        '{5'd3,  3'd2, 4'd0,  5'd5,  3'd4, 4'd0,  3'd0, 1'b1, 3'd4, 8'd69}, // R4 level dominates
        '{5'd10, 3'd3, 4'd7,  5'd2,  3'd3, 4'd1,  3'd0, 1'b1, 3'd3, 8'd74}, // R5 rank in level
        '{5'd9,  3'd5, 4'd4,  5'd20, 3'd5, 4'd4,  3'd0, 1'b1, 3'd5, 8'd73}, // R6 lower index
        '{5'd1,  3'd4, 4'd0,  5'd6,  3'd3, 4'd0,  3'd4, 1'b0, 3'd0, 8'd24}, // R7 equal mask, R11
        '{5'd31, 3'd7, 4'd0,  5'd0,  3'd1, 4'd0,  3'd7, 1'b1, 3'd7, 8'd95}, // R7 top level bypass
        '{5'd12, 3'd5, 4'd8,  5'd13, 3'd5, 4'd15, 3'd0, 1'b1, 3'd5, 8'd76}, // R5 saturation, R6
        '{5'd4,  3'd0, 4'd8,  5'd30, 3'd1, 4'd0,  3'd0, 1'b1, 3'd1, 8'd94}, // R12 level 0 parked
        '{5'd8,  3'd6, 4'd2,  5'd7,  3'd6, 4'd3,  3'd5, 1'b1, 3'd6, 8'd71}  // R5, R7 above mask
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] src_evt = '0;
    logic             glb_en = 1'b0;
    logic             cfg_wr = 1'b0;
    logic [4:0]       cfg_idx = '0;
    logic [2:0]       cfg_lvl = '0;
    logic [3:0]       cfg_sub = '0;
    logic             cfg_dis = 1'b0;
    logic             ack_vld = 1'b0;
    logic [4:0]       ack_idx = '0;
    logic [2:0]       core_mask = '0;
    logic             irq_req;
    logic [2:0]       irq_lvl;
    logic             vec_rd = 1'b0;
    logic             vec_vld;
    logic [7:0]       vec_num;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    lvl_irq_ctrl #(.N_SRC(N_SRC)) u_lvl_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .src_evt(src_evt), .glb_en(glb_en),
        .cfg_wr(cfg_wr), .cfg_idx(cfg_idx), .cfg_lvl(cfg_lvl), .cfg_sub(cfg_sub),
        .cfg_dis(cfg_dis), .ack_vld(ack_vld), .ack_idx(ack_idx),
        .core_mask(core_mask), .irq_req(irq_req), .irq_lvl(irq_lvl),
        .vec_rd(vec_rd), .vec_vld(vec_vld), .vec_num(vec_num)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input int idx, input int lvl, input int sub, input bit dis);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_idx = 5'(idx); cfg_lvl = 3'(lvl); cfg_sub = 4'(sub); cfg_dis = dis;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // One-cycle strobe; returns at the negedge after pending is set (3 edges).
    task automatic pulse(input logic [N_SRC-1:0] m);
        @(negedge clk);
        src_evt = m;
        @(negedge clk);
        src_evt = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic ack(input int idx);
        @(negedge clk);
        ack_vld = 1'b1; ack_idx = 5'(idx);
        @(negedge clk);
        ack_vld = 1'b0;
    endtask

    task automatic fetch(output int v, output int vv);
        @(negedge clk);
        vec_rd = 1'b1;
        @(negedge clk);
        vec_rd = 1'b0;
        v = int'(vec_num); vv = int'(vec_vld);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int v, vv;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        check("R13 irq_req", irq_req, 0);
        check("R13 irq_lvl", irq_lvl, 0);
        check("R13 vec_vld", vec_vld, 0);
        check("R13 vec_num", vec_num, 0);
        glb_en = 1'b1;
        // R13: a pulse to an unconfigured source stays blocked
        pulse(32'h1 << 11);
        check("R13 blocked default", irq_req, 0);
        ack(11);

        // Table walk
        for (int r = 0; r < NROW; r++) begin
            cfg(TBL[r].ia, TBL[r].la, TBL[r].sa, 1'b0);
            cfg(TBL[r].ib, TBL[r].lb, TBL[r].sb, 1'b0);
            core_mask = TBL[r].msk;
            pulse((32'h1 << TBL[r].ia) | (32'h1 << TBL[r].ib));
            check($sformatf("R4-row%0d irq_req", r), irq_req, TBL[r].er);
            check($sformatf("R7-row%0d irq_lvl", r), irq_lvl, TBL[r].el);
            fetch(v, vv);
            check($sformatf("R10-row%0d vec_num", r), v, TBL[r].ev);
            check($sformatf("R10-row%0d vec_vld", r), vv, 1);
            ack(TBL[r].ia);
            ack(TBL[r].ib);
            cfg(TBL[r].ia, 0, 0, 1'b1);
            cfg(TBL[r].ib, 0, 0, 1'b1);
        end
        core_mask = 3'd0;

        // R1 synchronizer latency
        cfg(3, 2, 0, 1'b0);
        @(negedge clk);
        src_evt = 32'h1 << 3;
        @(negedge clk);
        src_evt = '0;
        @(negedge clk);
        check("R1 not yet after two edges", irq_req, 0);
        @(negedge clk);
        check("R1 set after third edge", irq_req, 1);
        check("R1 level", irq_lvl, 2);

        // R3 master enable
        glb_en = 1'b0;
        #1;
        check("R3 glb off req", irq_req, 0);
        check("R3 glb off lvl", irq_lvl, 0);
        glb_en = 1'b1;
        #1;
        check("R3 glb back on", irq_req, 1);

        // R8 repeat events dropped: one ack clears
        pulse(32'h1 << 3);
        pulse(32'h1 << 3);
        ack(3);
        check("R8 one ack clears", irq_req, 0);

        // R2 blocked source keeps pending
        cfg(3, 2, 0, 1'b1);
        pulse(32'h1 << 3);
        check("R2 blocked no req", irq_req, 0);
        cfg(3, 2, 0, 1'b0);
        check("R2 held event shows", irq_req, 1);

        // R9 ack of another source leaves this one
        ack(4);
        check("R9 other ack ignored", irq_req, 1);
        ack(3);
        check("R9 own ack clears", irq_req, 0);

        // R9 ack and event on same edge: stays set
        @(negedge clk);
        src_evt = 32'h1 << 3;
        @(negedge clk);
        src_evt = '0;
        @(negedge clk);
        ack_vld = 1'b1; ack_idx = 5'd3;
        @(negedge clk);
        ack_vld = 1'b0;
        check("R9 set beats ack", irq_req, 1);
        fetch(v, vv);
        check("R10 vector for source 3", v, 67);
        ack(3);

        // R11 spurious
        fetch(v, vv);
        check("R11 spurious vector", v, 24);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule